// File: doc/BRIEF.md
# CCD Field and Frame Sequencer

This block steps an interline CCD through the lines of each field. It counts line strobes, marks the first line of every field, and tells the downstream line timing generator what each line must do: an ordinary line, a readout line, or a charge-sweep line. It works in two modes. Monitoring mode reads every fifth sensor row in short alternating fields. Still mode reads the full array as two interlaced fields and clears the vertical register with a charge sweep before each readout.

For each field the block also reports which group of sensor rows is delivered, as a first row and a row step. It raises the overflow-drain shutter pulse on a programmable line in monitoring fields, and drives a level control that selects the still-capture drain operation. A mode change requested by the host takes effect only at a field boundary. The first field produced in the new mode is marked as data to discard.

Top module: `ccd_field_seq`

## Requirements
- R1: After synchronous reset the sequencer is on line 1 of field 0 in monitoring mode: `vd_o`=1, `line_type_o`=0, `field_id_o`=0, `data_valid_o`=1, `shut_o`=0, `ofdc_o`=0, row group first=3 and step=5.
- R2: The line position advances only in a cycle where `hd_i` is high, and no output changes in any other cycle. `vd_o` is high for the whole of line 1 of every field and low on all other lines.
- R3: In monitoring mode, field 0 lasts 263 lines and field 1 lasts 262 lines, and the two alternate.
- R4: In still mode every field lasts 656 lines, and `field_id_o` alternates 0, 1 from one field to the next.
- R5: `mode_req_i` (0 = monitoring, 1 = still) is sampled only by the `hd_i` that ends the last line of a field. A different value switches the mode for the next field and restarts `field_id_o` at 0. A change in the middle of a field has no effect on that field.
- R6: `data_valid_o` is 0 for the whole first field after a mode switch and 1 for every other field.
- R7: `line_type_o` encodes 0 = normal, 1 = readout, 2 = charge sweep. In monitoring mode, line 2 is the only readout line and no line is a sweep.
- R8: In still mode the sweep runs from line 2 for ceil(stages/57) lines, then one readout line follows. In field 0 this is 1368 stages, so lines 2..25 are sweep lines and line 26 is the readout. In field 1 this is 684 stages, so lines 2..13 are sweep lines and line 14 is the readout.
- R9: Row group: monitoring mode gives first 3 and step 5. Still field 0 gives first 1 and step 2, and still field 1 gives first 2 and step 2.
- R10: `shut_line_i` is captured on each `hd_i`. In monitoring mode `shut_o` is high throughout the line equal to the captured value clamped to 1..field length, with 0 treated as 1. `shut_o` is never high in still mode.
- R11: `ofdc_o` is high throughout every still-mode field and low throughout every monitoring field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hd_i | input | 1 | Line strobe, one cycle per line |
| mode_req_i | input | 1 | Requested mode: 0 monitoring, 1 still |
| shut_line_i | input | LINE_W (10) | Shutter line number |
| vd_o | output | 1 | High during line 1 of a field |
| line_type_o | output | 2 | 0 normal, 1 readout, 2 sweep |
| field_id_o | output | 1 | Field index within the current mode |
| data_valid_o | output | 1 | Field data is usable |
| shut_o | output | 1 | Overflow-drain shutter line |
| ofdc_o | output | 1 | Still-capture drain control level |
| row_first_o | output | ROW_W (11) | First sensor row read this field |
| row_step_o | output | STEP_W (3) | Row spacing read this field |

## Verification
The properties assume that `hd_i` is a single-cycle strobe and that reset is applied synchronously. They also assume that nothing else moves the outputs, so outputs may change only on a line strobe, and mode-dependent signals may change only where a new field starts. The stimulus keeps to these assumptions. It changes `mode_req_i` and `shut_line_i` only in the cycle that carries a strobe, and it spaces the strobes one to three cycles apart. Mode requests are made in the middle of fields, to show that they are held until the boundary. Shutter values of 0, inside the range and beyond the field length exercise the clamp.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

    typedef enum logic [1:0] {
        LT_NORMAL  = 2'd0,
        LT_READOUT = 2'd1,
        LT_SWEEP   = 2'd2
    } line_kind_e;

    typedef enum logic {
        MD_MONITOR = 1'b0,
        MD_STILL   = 1'b1
    } seq_mode_e;

    typedef struct packed {
        seq_mode_e mode;
        logic      fid;
        logic      discard;
    } field_ctx_t;

    // lines needed to move a number of vertical stages at a fixed rate per line
    function automatic int unsigned sweep_lines(int unsigned stages, int unsigned per_line);
        return (stages + per_line - 1) / per_line;
    endfunction

endpackage

// File: rtl/ccdseq_line_ctr.sv
module ccdseq_line_ctr #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hd_i,
    input  logic [LINE_W-1:0] field_len_i,
    output logic [LINE_W-1:0] line_o,
    output logic              wrap_o
);
    logic [LINE_W-1:0] line_q;

    assign wrap_o = hd_i && (line_q == field_len_i);
    assign line_o = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= LINE_W'(1);
        end else if (hd_i) begin
            line_q <= wrap_o ? LINE_W'(1) : line_q + LINE_W'(1);
        end
    end
endmodule

// File: rtl/ccdseq_mode_ctl.sv
module ccdseq_mode_ctl
    import ccdseq_pkg::*;
#(
    parameter int LINE_W    = 10,
    parameter int MON_LEN_A = 263,
    parameter int MON_LEN_B = 262,
    parameter int STILL_LEN = 656
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap_i,
    input  logic              mode_req_i,
    output field_ctx_t        ctx_o,
    output logic [LINE_W-1:0] field_len_o
);
    field_ctx_t ctx_q;
    seq_mode_e  req_mode;

    assign req_mode = seq_mode_e'(mode_req_i);
    assign ctx_o    = ctx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q.mode    <= MD_MONITOR;
            ctx_q.fid     <= 1'b0;
            ctx_q.discard <= 1'b0;
        end else if (wrap_i) begin
            if (req_mode != ctx_q.mode) begin
                ctx_q.mode    <= req_mode;
                ctx_q.fid     <= 1'b0;
                ctx_q.discard <= 1'b1;
            end else begin
                ctx_q.fid     <= ~ctx_q.fid;
                ctx_q.discard <= 1'b0;
            end
        end
    end

    always_comb begin
        if (ctx_q.mode == MD_STILL)
            field_len_o = LINE_W'(STILL_LEN);
        else if (ctx_q.fid)
            field_len_o = LINE_W'(MON_LEN_B);
        else
            field_len_o = LINE_W'(MON_LEN_A);
    end
endmodule

// File: rtl/ccdseq_line_decode.sv
module ccdseq_line_decode
    import ccdseq_pkg::*;
#(
    parameter int LINE_W          = 10,
    parameter int ROW_W           = 11,
    parameter int STEP_W          = 3,
    parameter int READ_LINE       = 2,
    parameter int STAGES_PER_LINE = 57,
    parameter int SWEEP_STAGES_A  = 1368,
    parameter int SWEEP_STAGES_B  = 684,
    parameter int MON_ROW_FIRST   = 3,
    parameter int MON_ROW_STEP    = 5,
    parameter int STILL_ROW_STEP  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hd_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [LINE_W-1:0] field_len_i,
    input  logic [LINE_W-1:0] shut_line_i,
    input  field_ctx_t        ctx_i,
    output logic              vd_o,
    output line_kind_e        line_type_o,
    output logic              shut_o,
    output logic [ROW_W-1:0]  row_first_o,
    output logic [STEP_W-1:0] row_step_o
);
    localparam int XW   = LINE_W + 1;
    localparam int SW_A = int'(sweep_lines(SWEEP_STAGES_A, STAGES_PER_LINE));
    localparam int SW_B = int'(sweep_lines(SWEEP_STAGES_B, STAGES_PER_LINE));

    logic [LINE_W-1:0] shut_q;
    logic [LINE_W-1:0] shut_tgt;
    logic [XW-1:0]     line_x;
    logic [XW-1:0]     sweep_n;
    logic [XW-1:0]     read_x;
    logic              still;

    assign still  = (ctx_i.mode == MD_STILL);
    assign line_x = {1'b0, line_i};
    assign vd_o   = (line_i == LINE_W'(1));

    // shutter line captured per line so the output only moves on a strobe
    always_ff @(posedge clk) begin
        if (rst)       shut_q <= '1;
        else if (hd_i) shut_q <= shut_line_i;
    end

    always_comb begin
        if (shut_q == '0)
            shut_tgt = LINE_W'(1);
        else if (shut_q > field_len_i)
            shut_tgt = field_len_i;
        else
            shut_tgt = shut_q;
    end

    assign shut_o = !still && (line_i == shut_tgt);

    always_comb begin
        if (!still)       sweep_n = '0;
        else if (ctx_i.fid) sweep_n = XW'(SW_B);
        else              sweep_n = XW'(SW_A);
        read_x = XW'(READ_LINE) + sweep_n;
    end

    always_comb begin
        if (line_x >= XW'(READ_LINE) && line_x < read_x)
            line_type_o = LT_SWEEP;
        else if (line_x == read_x)
            line_type_o = LT_READOUT;
        else
            line_type_o = LT_NORMAL;
    end

    always_comb begin
        if (still) begin
            row_first_o = ctx_i.fid ? ROW_W'(2) : ROW_W'(1);
            row_step_o  = STEP_W'(STILL_ROW_STEP);
        end else begin
            row_first_o = ROW_W'(MON_ROW_FIRST);
            row_step_o  = STEP_W'(MON_ROW_STEP);
        end
    end
endmodule

// File: rtl/ccd_field_seq.sv
module ccd_field_seq
    import ccdseq_pkg::*;
#(
    parameter int MON_LEN_A       = 263,
    parameter int MON_LEN_B       = 262,
    parameter int STILL_LEN       = 656,
    parameter int READ_LINE       = 2,
    parameter int STAGES_PER_LINE = 57,
    parameter int SWEEP_STAGES_A  = 1368,
    parameter int SWEEP_STAGES_B  = 684,
    parameter int SENSOR_ROWS     = 1250,
    parameter int MON_ROW_FIRST   = 3,
    parameter int MON_ROW_STEP    = 5,
    parameter int STILL_ROW_STEP  = 2,
    localparam int LINE_W = $clog2(STILL_LEN + 1),
    localparam int ROW_W  = $clog2(SENSOR_ROWS + 1),
    localparam int STEP_W = $clog2(MON_ROW_STEP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hd_i,
    input  logic              mode_req_i,
    input  logic [LINE_W-1:0] shut_line_i,
    output logic              vd_o,
    output logic [1:0]        line_type_o,
    output logic              field_id_o,
    output logic              data_valid_o,
    output logic              shut_o,
    output logic              ofdc_o,
    output logic [ROW_W-1:0]  row_first_o,
    output logic [STEP_W-1:0] row_step_o
);
    logic [LINE_W-1:0] line_w;
    logic [LINE_W-1:0] field_len_w;
    logic              wrap_w;
    field_ctx_t        ctx_w;
    line_kind_e        kind_w;

    ccdseq_line_ctr #(.LINE_W(LINE_W)) u_ctr (
        .clk         (clk),
        .rst         (rst),
        .hd_i        (hd_i),
        .field_len_i (field_len_w),
        .line_o      (line_w),
        .wrap_o      (wrap_w)
    );

    ccdseq_mode_ctl #(
        .LINE_W    (LINE_W),
        .MON_LEN_A (MON_LEN_A),
        .MON_LEN_B (MON_LEN_B),
        .STILL_LEN (STILL_LEN)
    ) u_mode (
        .clk         (clk),
        .rst         (rst),
        .wrap_i      (wrap_w),
        .mode_req_i  (mode_req_i),
        .ctx_o       (ctx_w),
        .field_len_o (field_len_w)
    );

    ccdseq_line_decode #(
        .LINE_W          (LINE_W),
        .ROW_W           (ROW_W),
        .STEP_W          (STEP_W),
        .READ_LINE       (READ_LINE),
        .STAGES_PER_LINE (STAGES_PER_LINE),
        .SWEEP_STAGES_A  (SWEEP_STAGES_A),
        .SWEEP_STAGES_B  (SWEEP_STAGES_B),
        .MON_ROW_FIRST   (MON_ROW_FIRST),
        .MON_ROW_STEP    (MON_ROW_STEP),
        .STILL_ROW_STEP  (STILL_ROW_STEP)
    ) u_dec (
        .clk         (clk),
        .rst         (rst),
        .hd_i        (hd_i),
        .line_i      (line_w),
        .field_len_i (field_len_w),
        .shut_line_i (shut_line_i),
        .ctx_i       (ctx_w),
        .vd_o        (vd_o),
        .line_type_o (kind_w),
        .shut_o      (shut_o),
        .row_first_o (row_first_o),
        .row_step_o  (row_step_o)
    );

    assign line_type_o  = kind_w;
    assign field_id_o   = ctx_w.fid;
    assign data_valid_o = !ctx_w.discard;
    assign ofdc_o       = (ctx_w.mode == MD_STILL);
endmodule

// File: rtl/ccd_field_seq_chk.sv
module ccd_field_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       hd,
    input logic       vd,
    input logic [1:0] line_type,
    input logic       field_id,
    input logic       data_valid,
    input logic       shut,
    input logic       ofdc
);
    assert_quiet_between_strobes_R2: assert property (@(posedge clk) disable iff (rst)
        !hd |=> $stable({vd, line_type, field_id, data_valid, shut, ofdc}));

    assert_kind_legal_R7: assert property (@(posedge clk) disable iff (rst)
        line_type != 2'd3);

    assert_sweep_only_still_R8: assert property (@(posedge clk) disable iff (rst)
        (line_type == 2'd2) |-> ofdc);

    assert_no_shutter_in_still_R10: assert property (@(posedge clk) disable iff (rst)
        shut |-> !ofdc);

    assert_ofdc_moves_at_field_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(ofdc) |-> vd);

    assert_fid_moves_at_field_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(field_id) |-> vd);

    assert_discard_on_switch_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(data_valid) |-> (vd && !$stable(ofdc)));
endmodule

bind ccd_field_seq ccd_field_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hd         (hd_i),
    .vd         (vd_o),
    .line_type  (line_type_o),
    .field_id   (field_id_o),
    .data_valid (data_valid_o),
    .shut       (shut_o),
    .ofdc       (ofdc_o)
);

// File: tb/sim_ccd_field_seq.sv
`timescale 1ns/1ps
module sim_ccd_field_seq;

    typedef struct {
        int    vd;
        int    lt;
        int    fid;
        int    dv;
        int    sh;
        int    of;
        int    rf;
        int    rs;
        string tag_len;
        string tag_lt;
        string tag_fid;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hd = 1'b0;
    logic        mode_req = 1'b0;
    logic [9:0]  shut_line = 10'd100;
    logic        vd, fid, dv, sh, of;
    logic [1:0]  lt;
    logic [10:0] rf;
    logic [2:0]  rs;

    int n_chk = 0;
    int n_err = 0;
    bit mon_on = 0;
    bit done = 0;

    // reference state kept by the bench
    int m_line = 1;
    int m_mode = 0;
    int m_fid = 0;
    int m_inv = 0;
    int m_shut = 1023;
    int nxt_shut = 100;
    int nxt_req = 0;

    exp_t q[$];
    exp_t cur;

    always #5 clk = ~clk;

    ccd_field_seq u0 (
        .clk          (clk),
        .rst          (rst),
        .hd_i         (hd),
        .mode_req_i   (mode_req),
        .shut_line_i  (shut_line),
        .vd_o         (vd),
        .line_type_o  (lt),
        .field_id_o   (fid),
        .data_valid_o (dv),
        .shut_o       (sh),
        .ofdc_o       (of),
        .row_first_o  (rf),
        .row_step_o   (rs)
    );

    function automatic int flen(int mode, int f);
        if (mode == 1) return 656;   // R4
        return (f == 1) ? 262 : 263; // R3
    endfunction

    function automatic exp_t build();
        exp_t e;
        int len = flen(m_mode, m_fid);
        int tgt = (m_shut == 0) ? 1 : ((m_shut > len) ? len : m_shut);
        int nsw = (m_mode == 1) ? ((m_fid == 1) ? 12 : 24) : 0;
        e.vd  = (m_line == 1);
        if (m_line >= 2 && m_line < 2 + nsw) e.lt = 2;
        else if (m_line == 2 + nsw)          e.lt = 1;
        else                                 e.lt = 0;
        e.fid = m_fid;
        e.dv  = !m_inv;
        e.sh  = (m_mode == 0) && (m_line == tgt);
        e.of  = m_mode;
        e.rf  = (m_mode == 0) ? 3 : ((m_fid == 1) ? 2 : 1);
        e.rs  = (m_mode == 0) ? 5 : 2;
        e.tag_len = (m_mode == 1) ? "R4" : "R3";
        e.tag_lt  = (m_mode == 1) ? "R8" : "R7";
        e.tag_fid = (m_inv == 1) ? "R5" : "R4";
        return e;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(exp_t e);
        chk(e.tag_len, "vd (R2 line 1 only)", vd, e.vd);
        chk(e.tag_lt, "line_type", lt, e.lt);
        chk(e.tag_fid, "field_id", fid, e.fid);
        chk("R6", "data_valid", dv, e.dv);
        chk("R10", "shut", sh, e.sh);
        chk("R11", "ofdc", of, e.of);
        chk("R9", "row_first", rf, e.rf);
        chk("R9", "row_step", rs, e.rs);
    endtask

    // advance the reference on one strobe (R5: request seen only on last line)
    task automatic model_hd();
        int len = flen(m_mode, m_fid);
        m_shut = nxt_shut;
        if (m_line == len) begin
            if (nxt_req != m_mode) begin
                m_mode = nxt_req;
                m_fid  = 0;
                m_inv  = 1;
            end else begin
                m_fid = 1 - m_fid;
                m_inv = 0;
            end
            m_line = 1;
        end else begin
            m_line++;
        end
    endtask

    // driver: one strobe, inputs change only with it, then idle cycles
    task automatic hd_line(int idle);
        @(negedge clk);
        hd        = 1'b1;
        shut_line = 10'(nxt_shut);
        mode_req  = nxt_req[0];
        model_hd();
        q.push_back(build());
        @(negedge clk);
        hd = 1'b0;
        repeat (idle) @(negedge clk);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) hd_line(i % 3);
    endtask

    // monitor: applies each expected item at its strobe edge, checks every cycle
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_on) begin
                if (q.size() > 0) cur = q.pop_front();
                compare(cur);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R2 watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "vd", vd, 1);
        chk("R1", "line_type", lt, 0);
        chk("R1", "field_id", fid, 0);
        chk("R1", "data_valid", dv, 1);
        chk("R1", "shut", sh, 0);
        chk("R1", "ofdc", of, 0);
        chk("R1", "row_first", rf, 3);
        chk("R1", "row_step", rs, 5);
        cur    = build();
        mon_on = 1;

        run(40);                 // monitoring, shutter on line 100
        nxt_shut = 0;   run(500);  // 0 treated as line 1
        nxt_shut = 1000; run(300); // clamped to field end
        nxt_shut = 120; run(100);
        nxt_req = 1;    run(2900); // request mid-field, held to boundary
        nxt_shut = 5;   run(300);  // shutter value ignored in still mode
        nxt_req = 0;    run(1000);
        repeat (3) @(negedge clk);
        mon_on = 0;
        done   = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule